// File: doc/BRIEF.md
# Video field capture controller for asynchronous SRAM

This block stores one interlaced video field, or several fields back to back, into an external byte-wide asynchronous SRAM. A host arms it. The block then waits for the field indicator to rise, which marks the start of an odd field. From that point it digitises the active part of each line into memory, and it reports completion when the indicator rises again. After completion the host takes the memory bus and reads the stored picture out one byte at a time. Each read moves the address on by one.

All inputs are sampled on the system clock `clk`, including the pixel clock. The edges of the pixel clock are detected inside the block:

- A rising pixel-clock edge inside the sample window starts a conversion (`adc_convert`) and latches the converted byte. From the second sample of a run onward, the same edge also steps the memory address.
- A falling pixel-clock edge commits the latched byte. The block first asserts chip select alone for one cycle, then holds chip select and write enable low together for a programmable number of cycles. This stretches the write pulse past the SRAM's minimum write time.

Only the host clears the address counter. Fields captured after separate arm requests therefore stack one after another in memory. The counter stops at its top location and raises an overflow flag instead of wrapping.

Top module: `fcap_top`

## Requirements
- R1: After `host_arm`, `cap_started` and `cap_done` read 0. The first 0-to-1 transition of `vid_field` seen while armed sets `cap_started`, visible one clock after the edge is sampled. Before the first arm after reset, `vid_field` edges have no effect.
- R2: The next 0-to-1 transition of `vid_field` after start sets `cap_done`. Further transitions leave both flags unchanged until the next `host_arm`.
- R3: While capture is active (started and not done), `vid_window` is 1 and no overflow is flagged, each rising `vid_pclk` edge produces a one-cycle `adc_convert` pulse in the following cycle and latches `adc_data` as the byte to store.
- R4: The falling `vid_pclk` edge after a latched sample starts a write. `sram_ce_n` goes low for one cycle alone, then `sram_ce_n` and `sram_we_n` are both low for `WE_CYCLES` cycles, with address and data held stable throughout.
- R5: No write starts when capture is inactive, when `vid_window` is 0, or when no sample has been latched.
- R6: The first sample after an address clear goes to address 0. Each later sample goes to the next address. Only `host_addr_clr` returns the address to 0, so fields captured after separate arm requests follow on in memory.
- R7: `bus_cap` is 1 while capture is active or a write is in progress. During that time `host_rd` is ignored and `sram_oe_n` stays 1.
- R8: A `host_rd` accepted while the bus is free drives `sram_oe_n` low for `RD_CYCLES` cycles. It then returns the byte at the current address on `host_rd_data` with a one-cycle `host_rd_valid` pulse, and the address increases by one (saturating at the top).
- R9: When a sample would need an address beyond 2^`ADDR_W`-1, the address stays at the top location, `cap_ovf` is set and no further writes occur. `host_addr_clr` clears the flag.
- R10: After synchronous reset, all flags read 0, the address is 0, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, and `bus_cap` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_arm | input | 1 | Clears start/done and arms for the next odd field |
| host_addr_clr | input | 1 | Returns the address counter to 0 and clears overflow |
| host_rd | input | 1 | Read strobe; reads the current byte, then steps the address |
| host_rd_data | output | DATA_W | Byte returned by the last read |
| host_rd_valid | output | 1 | One-cycle pulse when `host_rd_data` is updated |
| cap_started | output | 1 | Capture start seen |
| cap_done | output | 1 | Capture completed at the next field boundary |
| cap_ovf | output | 1 | Address counter saturated during capture |
| vid_field | input | 1 | Field indicator; a rise marks the start of an odd field |
| vid_window | input | 1 | Active part of the line where samples are stored |
| vid_pclk | input | 1 | Pixel clock, sampled on `clk` |
| adc_data | input | DATA_W | Converted sample from the converter |
| adc_convert | output | 1 | Conversion start pulse |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| bus_cap | output | 1 | 1 when the capture engine owns the SRAM bus, 0 when the host does |

## Verification
A start/stop sequencer in the wrong state shows up within one clock as a wrong `cap_started` or `cap_done`. It also shows up on the next pixel edge as a conversion pulse or write strobe that should not be there. A slipped address counter appears on `sram_addr` at the very next sample or read, and as bytes landing at the wrong memory locations once the host reads them back. A miscounted write timer is visible in the same cycle as a chip-select/write-enable pattern of the wrong length, or as a bus handover to the host that comes too early or too late.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } sram_ctl_t;
endpackage

// File: rtl/fcap_edge_det.sv
module fcap_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;
endmodule

// File: rtl/fcap_field_seq.sv
module fcap_field_seq (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic field_lvl,
  output logic started,
  output logic stopped
);
  logic prev_q, armed_q, start_q, stop_q;
  logic fedge;

  assign fedge = field_lvl & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      prev_q <= field_lvl;
      if (arm) begin
        armed_q <= 1'b1;
        start_q <= 1'b0;
        stop_q  <= 1'b0;
      end else if (fedge) begin
        if (armed_q && !start_q)     start_q <= 1'b1;
        else if (start_q && !stop_q) stop_q  <= 1'b1;
      end
    end
  end

  assign started = start_q;
  assign stopped = stop_q;
endmodule

// File: rtl/fcap_addr_ctr.sv
module fcap_addr_ctr #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_max
);
  logic [ADDR_W-1:0] cnt_q;

  assign at_max = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)         cnt_q <= '0;
    else if (inc && !at_max) cnt_q <= cnt_q + ADDR_W'(1);
  end

  assign addr = cnt_q;
endmodule

// File: rtl/fcap_wr_strobe.sv
module fcap_wr_strobe #(
  parameter int WE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic we
);
  localparam int CW = $clog2(WE_CYCLES + 2);
  logic [CW-1:0] cnt_q;
  logic          we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      we_q  <= 1'b0;
    end else if (start) begin
      cnt_q <= CW'(WE_CYCLES + 1);
      we_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      we_q  <= (cnt_q != CW'(1));
    end
  end

  assign busy = (cnt_q != '0);
  assign we   = we_q;
endmodule

// File: rtl/fcap_top.sv
module fcap_top
  import fcap_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int WE_CYCLES = 3,
  parameter int RD_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_arm,
  input  logic              host_addr_clr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              host_rd_valid,
  output logic              cap_started,
  output logic              cap_done,
  output logic              cap_ovf,
  input  logic              vid_field,
  input  logic              vid_window,
  input  logic              vid_pclk,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_convert,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              bus_cap
);
  localparam int RC_W = $clog2(RD_CYCLES + 1);

  logic              started, stopped, active;
  logic              p_rise, p_fall;
  logic [ADDR_W-1:0] addr;
  logic              at_max;
  logic              wr_start, wr_busy, wr_we;
  logic              have_q, wrote_q, ovf_q, conv_q;
  logic [DATA_W-1:0] data_q, rd_data_q;
  logic [RC_W-1:0]   rd_cnt;
  logic              oe_q, rv_q;
  logic              smp_ok, cap_inc, rd_inc, rd_go, bus_own;
  sram_ctl_t         ctl;

  fcap_field_seq u_seq (
    .clk(clk), .rst(rst), .arm(host_arm), .field_lvl(vid_field),
    .started(started), .stopped(stopped)
  );

  fcap_edge_det u_pclk (
    .clk(clk), .rst(rst), .sig(vid_pclk), .rise(p_rise), .fall(p_fall)
  );

  fcap_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .clr(host_addr_clr), .inc(cap_inc | rd_inc),
    .addr(addr), .at_max(at_max)
  );

  fcap_wr_strobe #(.WE_CYCLES(WE_CYCLES)) u_wr (
    .clk(clk), .rst(rst), .start(wr_start), .busy(wr_busy), .we(wr_we)
  );

  assign active   = started & ~stopped;
  assign smp_ok   = active & vid_window & ~ovf_q;
  assign cap_inc  = p_rise & smp_ok & wrote_q & ~at_max;
  assign wr_start = p_fall & smp_ok & have_q & ~wr_busy;
  assign bus_own  = active | wr_busy;
  assign rd_go    = host_rd & ~bus_own & (rd_cnt == '0);
  assign rd_inc   = (rd_cnt == RC_W'(1));

  // capture engine: sample on rising pixel edge, commit on falling edge
  always_ff @(posedge clk) begin
    conv_q <= 1'b0;
    if (rst) begin
      have_q  <= 1'b0;
      wrote_q <= 1'b0;
      ovf_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (p_rise && smp_ok) begin
        conv_q  <= 1'b1;
        data_q  <= adc_data;
        wrote_q <= 1'b0;
        if (wrote_q && at_max) ovf_q  <= 1'b1;
        else                   have_q <= 1'b1;
      end
      if (wr_start) begin
        have_q  <= 1'b0;
        wrote_q <= 1'b1;
      end
      if (host_addr_clr) begin
        have_q  <= 1'b0;
        wrote_q <= 1'b0;
        ovf_q   <= 1'b0;
      end
    end
  end

  // host read sequencer
  always_ff @(posedge clk) begin
    rv_q <= 1'b0;
    if (rst) begin
      rd_cnt    <= '0;
      oe_q      <= 1'b0;
      rd_data_q <= '0;
    end else if (rd_go) begin
      rd_cnt <= RC_W'(RD_CYCLES);
      oe_q   <= 1'b1;
    end else if (rd_cnt != '0) begin
      rd_cnt <= rd_cnt - RC_W'(1);
      if (rd_inc) begin
        oe_q      <= 1'b0;
        rd_data_q <= sram_rdata;
        rv_q      <= 1'b1;
      end
    end
  end

  assign ctl = '{ce_n: ~(wr_busy | oe_q), we_n: ~wr_we, oe_n: ~oe_q};

  assign sram_ce_n     = ctl.ce_n;
  assign sram_we_n     = ctl.we_n;
  assign sram_oe_n     = ctl.oe_n;
  assign sram_addr     = addr;
  assign sram_wdata    = data_q;
  assign bus_cap       = bus_own;
  assign adc_convert   = conv_q;
  assign cap_started   = started;
  assign cap_done      = stopped;
  assign cap_ovf       = ovf_q;
  assign host_rd_data  = rd_data_q;
  assign host_rd_valid = rv_q;
endmodule

// File: rtl/fcap_chk.sv
module fcap_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              host_addr_clr,
  input logic              cap_started,
  input logic              cap_done,
  input logic              cap_ovf,
  input logic              adc_convert,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              bus_cap
);
  p_we_with_ce_r4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n);

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |=> (sram_we_n || $stable(sram_addr)));

  p_we_owned_r5: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> bus_cap);

  p_no_oe_cap_r7: assert property (@(posedge clk) disable iff (rst)
    bus_cap |-> sram_oe_n);

  p_conv_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    adc_convert |=> !adc_convert);

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    cap_done |-> cap_started);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (sram_addr != $past(sram_addr)) |->
      ($past(rst) || $past(host_addr_clr) ||
       sram_addr == ADDR_W'($past(sram_addr) + 1)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (cap_ovf && !host_addr_clr) |=> cap_ovf);
endmodule

bind fcap_top fcap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_addr_clr(host_addr_clr),
  .cap_started(cap_started), .cap_done(cap_done), .cap_ovf(cap_ovf),
  .adc_convert(adc_convert), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
  .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .bus_cap(bus_cap)
);

// File: tb/tb_fcap_top.sv
module tb_fcap_top;
  localparam int AW  = 6;
  localparam int DW  = 8;
  localparam int WE  = 3;
  localparam int RD  = 3;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic host_arm = 0, host_addr_clr = 0, host_rd = 0;
  logic [DW-1:0] host_rd_data;
  logic host_rd_valid, cap_started, cap_done, cap_ovf;
  logic vid_field = 0, vid_window = 0, vid_pclk = 0;
  logic [DW-1:0] adc_data = '0;
  logic adc_convert;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata, sram_rdata;
  logic sram_ce_n, sram_we_n, sram_oe_n, bus_cap;

  logic [DW-1:0] mem [0:TOP];

  int vectors = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fcap_top #(.ADDR_W(AW), .DATA_W(DW), .WE_CYCLES(WE), .RD_CYCLES(RD)) dut (
    .clk(clk), .rst(rst), .host_arm(host_arm), .host_addr_clr(host_addr_clr),
    .host_rd(host_rd), .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
    .cap_started(cap_started), .cap_done(cap_done), .cap_ovf(cap_ovf),
    .vid_field(vid_field), .vid_window(vid_window), .vid_pclk(vid_pclk),
    .adc_data(adc_data), .adc_convert(adc_convert), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .bus_cap(bus_cap)
  );

  // behavioural SRAM
  assign sram_rdata = mem[sram_addr];
  always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, integers only
  int  m_addr, m_wcnt, m_rcnt, m_rd;
  bit  m_arm, m_start, m_stop, m_have, m_wrote, m_ovf, m_conv, m_rv, m_pf, m_pp;
  logic [DW-1:0] m_data;

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_wcnt = 0; m_rcnt = 0; m_rd = 0;
      m_arm = 0; m_start = 0; m_stop = 0; m_have = 0; m_wrote = 0;
      m_ovf = 0; m_conv = 0; m_rv = 0; m_pf = 0; m_pp = 0; m_data = '0;
    end else begin
      bit cap, busy, ok, frise, prise, pfall, step;
      bit n_arm, n_start, n_stop, n_have, n_wrote, n_ovf;
      int n_wcnt, n_rcnt;
      cap   = m_start && !m_stop;
      busy  = cap || (m_wcnt != 0);
      ok    = cap && vid_window && !m_ovf;
      frise = vid_field && !m_pf;
      prise = vid_pclk && !m_pp;
      pfall = !vid_pclk && m_pp;
      n_arm = m_arm; n_start = m_start; n_stop = m_stop;
      n_have = m_have; n_wrote = m_wrote; n_ovf = m_ovf;
      n_wcnt = m_wcnt; n_rcnt = m_rcnt; step = 0;
      m_conv = 0; m_rv = 0;
      if (host_arm) begin n_arm = 1; n_start = 0; n_stop = 0; end
      else if (frise) begin
        if (m_arm && !m_start) n_start = 1;
        else if (m_start && !m_stop) n_stop = 1;
      end
      if (prise && ok) begin
        m_conv = 1; m_data = adc_data; n_wrote = 0;
        if (m_wrote && m_addr == TOP) n_ovf = 1;
        else begin n_have = 1; if (m_wrote) step = 1; end
      end
      if (pfall && ok && m_have && m_wcnt == 0) begin
        n_wcnt = WE + 1; n_have = 0; n_wrote = 1;
      end else if (m_wcnt != 0) n_wcnt = m_wcnt - 1;
      if (host_rd && !busy && m_rcnt == 0) n_rcnt = RD;
      else if (m_rcnt != 0) begin
        n_rcnt = m_rcnt - 1;
        if (m_rcnt == 1) begin m_rd = mem[m_addr]; m_rv = 1; step = 1; end
      end
      if (host_addr_clr) begin
        m_addr = 0; n_have = 0; n_wrote = 0; n_ovf = 0;
      end else if (step && m_addr != TOP) m_addr = m_addr + 1;
      m_arm = n_arm; m_start = n_start; m_stop = n_stop; m_have = n_have;
      m_wrote = n_wrote; m_ovf = n_ovf; m_wcnt = n_wcnt; m_rcnt = n_rcnt;
      m_pf = vid_field; m_pp = vid_pclk;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) if (!rst && !finished) begin
    chk(cap_started == m_start, "R1 cap_started", cap_started, m_start);
    chk(cap_done == m_stop, "R2 cap_done", cap_done, m_stop);
    chk(adc_convert == m_conv, "R3 adc_convert", adc_convert, m_conv);
    chk(sram_we_n == !(m_wcnt >= 1 && m_wcnt <= WE), "R4 sram_we_n", sram_we_n,
        !(m_wcnt >= 1 && m_wcnt <= WE));
    chk(sram_ce_n == !(m_wcnt != 0 || m_rcnt != 0), "R4 sram_ce_n", sram_ce_n,
        !(m_wcnt != 0 || m_rcnt != 0));
    chk(int'(sram_addr) == m_addr, "R6 sram_addr", sram_addr, m_addr);
    chk(bus_cap == ((m_start && !m_stop) || m_wcnt != 0), "R7 bus_cap", bus_cap,
        (m_start && !m_stop) || m_wcnt != 0);
    chk(sram_oe_n == (m_rcnt == 0), "R8 sram_oe_n", sram_oe_n, m_rcnt == 0);
    chk(host_rd_valid == m_rv, "R8 host_rd_valid", host_rd_valid, m_rv);
    if (m_rv) chk(int'(host_rd_data) == m_rd, "R8 host_rd_data", host_rd_data, m_rd);
    chk(cap_ovf == m_ovf, "R9 cap_ovf", cap_ovf, m_ovf);
    if (m_conv) chk(sram_wdata == m_data, "R3 sram_wdata", sram_wdata, m_data);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arm();
    host_arm = 1; cyc(1); host_arm = 0; cyc(1);
  endtask

  task automatic pulse_clr();
    host_addr_clr = 1; cyc(1); host_addr_clr = 0; cyc(1);
  endtask

  task automatic field_edge();
    vid_field = 1; cyc(3); vid_field = 0; cyc(3);
  endtask

  task automatic line(input int n, input logic [DW-1:0] base);
    vid_window = 1;
    for (int i = 0; i < n; i++) begin
      vid_pclk = 1; adc_data = base + DW'(i); cyc(5);
      vid_pclk = 0; cyc(5);
    end
    cyc(2); vid_window = 0; cyc(2);
  endtask

  task automatic host_read(input logic [DW-1:0] exp, input string req);
    host_rd = 1; cyc(1); host_rd = 0; cyc(RD);
    chk(host_rd_valid == 1'b1, req, host_rd_valid, 1);
    chk(host_rd_data == exp, req, host_rd_data, exp);
    cyc(1);
  endtask

  initial begin
    for (int i = 0; i <= TOP; i++) mem[i] = 8'hEE;
    cyc(5); rst = 0; cyc(1);
    // R10 reset state
    chk(!cap_started && !cap_done && !cap_ovf, "R10 flags", {cap_started, cap_done, cap_ovf}, 0);
    chk(sram_addr == '0, "R10 addr", sram_addr, 0);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !bus_cap, "R10 bus",
        {sram_ce_n, sram_we_n, sram_oe_n, bus_cap}, 4'b1110);

    // R5 / R1: no capture before arming, field edge ignored when not armed
    field_edge();
    chk(cap_started == 1'b0, "R1 edge before arm", cap_started, 0);
    line(4, 8'h55);
    chk(mem[0] == 8'hEE, "R5 pre-arm write", mem[0], 8'hEE);
    pulse_arm();
    line(4, 8'h66);
    chk(mem[0] == 8'hEE, "R5 armed no field", mem[0], 8'hEE);

    // R1 start, R3/R4 line capture
    field_edge();
    chk(cap_started && !cap_done, "R1 start", {cap_started, cap_done}, 2'b10);
    line(10, 8'h10);
    for (int i = 0; i < 10; i++) chk(mem[i] == 8'h10 + DW'(i), "R4 stored byte", mem[i], 8'h10 + i);
    // R5 pixel clock outside window
    for (int i = 0; i < 3; i++) begin vid_pclk = 1; cyc(5); vid_pclk = 0; cyc(5); end
    chk(sram_addr == AW'(9) && mem[10] == 8'hEE, "R5 window low", sram_addr, 9);

    // R2 stop, later edges ignored
    field_edge();
    chk(cap_done == 1'b1, "R2 stop", cap_done, 1);
    line(3, 8'h77);
    chk(mem[10] == 8'hEE, "R5 after done", mem[10], 8'hEE);
    field_edge();
    chk(cap_started && cap_done, "R2 extra edge", {cap_started, cap_done}, 2'b11);

    // R8 read back
    pulse_clr();
    for (int i = 0; i < 10; i++) host_read(8'h10 + DW'(i), "R8 readback");
    chk(sram_addr == AW'(10), "R8 address step", sram_addr, 10);

    // R6 stacked fields, R7 read ignored during capture
    pulse_clr(); pulse_arm(); field_edge();
    host_rd = 1; cyc(1); host_rd = 0; cyc(5);
    chk(sram_oe_n == 1'b1 && bus_cap, "R7 read ignored", sram_oe_n, 1);
    line(5, 8'hA0); field_edge();
    pulse_arm(); field_edge(); line(5, 8'hB0); field_edge();
    for (int i = 0; i < 5; i++) begin
      chk(mem[i] == 8'hA0 + DW'(i), "R6 first field", mem[i], 8'hA0 + i);
      chk(mem[i + 5] == 8'hB0 + DW'(i), "R6 second field", mem[i + 5], 8'hB0 + i);
    end
    pulse_clr();
    host_read(8'hA0, "R6 stacked read");

    // R9 saturation
    pulse_clr(); pulse_arm(); field_edge();
    line(TOP + 7, 8'h40);
    chk(cap_ovf == 1'b1, "R9 overflow flag", cap_ovf, 1);
    chk(sram_addr == AW'(TOP), "R9 saturated addr", sram_addr, TOP);
    chk(mem[TOP] == 8'h40 + DW'(TOP), "R9 last byte", mem[TOP], 8'h40 + TOP);
    chk(mem[0] == 8'h40, "R9 first byte kept", mem[0], 8'h40);
    field_edge();
    pulse_clr();
    chk(cap_ovf == 1'b0, "R9 clear", cap_ovf, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule